// File: doc/BRIEF.md
# Mode-Selectable Word Funnel Shifter

This block shifts or rotates one 32-bit word by 0 to 31 places in a single combinational pass. Five operations are offered: zero-filling shifts in both directions, a sign-filling right shift, and rotations in both directions. The block has no clock and no state. The result follows the inputs within the same evaluation.

Every operation uses the same datapath. A setup stage turns the operation code and the amount into three values: an upper word, a lower word and a right offset. A shared extractor joins the two words into a 64-bit value and shifts it right by the offset. It does this in five stages of 2:1 multiplexers, and each stage is steered by one bit of the offset. The lower 32 bits of that value are the result. Left operations are mapped to a right offset of 32 minus the amount. An amount of zero on a left operation is mapped so that the operand passes through unchanged.

Top module: `fsh_unit`

## Requirements
- R1: With mode code 3'b000, the result is the operand shifted toward the MSB by `shamt` places, with zeros entering at bit 0.
- R2: With mode code 3'b001, the result is the operand shifted toward the LSB by `shamt` places, with zeros entering at bit 31.
- R3: With mode code 3'b010, the result is the operand shifted toward the LSB by `shamt` places, with copies of operand bit 31 entering at bit 31.
- R4: With mode code 3'b011, the result is the operand rotated toward the LSB by `shamt` places. Bits that leave at bit 0 re-enter at bit 31, so the number of set bits is preserved.
- R5: With mode code 3'b100, the result is the operand rotated toward the MSB by `shamt` places. Bits that leave at bit 31 re-enter at bit 0, so the number of set bits is preserved.
- R6: When `shamt` is zero, the result equals the operand for every mode code.
- R7: Mode codes 3'b101, 3'b110 and 3'b111 return the operand unchanged, whatever the value of `shamt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | Operand word |
| shamt | input | 5 | Shift or rotate amount, 0 to 31 |
| mode | input | 3 | Operation code (see R1 to R7) |
| res | output | 32 | Shifted or rotated word |

## Verification
The hardest cases are the left operations at an amount of zero. There, the offset 32 minus the amount would wrap to zero and select the wrong word, so the setup stage must treat that case specially. The stimulus reaches it in two ways: a sweep over every amount from 0 to 31 for each mode, using fresh random operands, and a directed vector that sends the value 0 with both left codes. Operands with bit 31 set are also driven in the sign-filling mode at the largest amount, so the whole result is built from fill bits.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int WORD_W = 32;
  localparam int AMT_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    MODE_SHL = 3'b000,
    MODE_SHR = 3'b001,
    MODE_SAR = 3'b010,
    MODE_ROR = 3'b011,
    MODE_ROL = 3'b100
  } shift_mode_e;

  // a right offset that realises a leftward move of amt places
  function automatic logic [AMT_W-1:0] left_to_right(input logic [AMT_W-1:0] amt);
    return AMT_W'(0) - amt;
  endfunction

  function automatic logic mode_defined(input logic [2:0] code);
    return code <= 3'b100;
  endfunction
endpackage

// File: rtl/fsh_setup.sv
module fsh_setup
  import fsh_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amt,
  input  logic [2:0]    code,
  output logic [W-1:0]  y_word,
  output logic [W-1:0]  x_word,
  output logic [AW-1:0] offset
);
  logic amt_zero;
  assign amt_zero = (amt == '0);

  always_comb begin
    y_word = '0;
    x_word = a;
    offset = amt;
    case (shift_mode_e'(code))
      MODE_SHL: begin
        y_word = a;
        x_word = amt_zero ? a : '0;
        offset = AW'(0) - amt;
      end
      MODE_SHR: begin
        y_word = '0;
      end
      MODE_SAR: begin
        y_word = {W{a[W-1]}};
      end
      MODE_ROR: begin
        y_word = a;
      end
      MODE_ROL: begin
        y_word = a;
        offset = AW'(0) - amt;
      end
      default: begin
        y_word = '0;
        offset = '0;
      end
    endcase
  end
endmodule

// File: rtl/fsh_extract.sv
module fsh_extract #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [2*W-1:0] cat,
  input  logic [AW-1:0]  offset,
  output logic [W-1:0]   window
);
  logic [2*W-1:0] stage [AW+1];

  assign stage[0] = cat;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    assign stage[k+1] = offset[k] ? (stage[k] >> (2**k)) : stage[k];
  end

  assign window = stage[AW][W-1:0];
endmodule

// File: rtl/fsh_unit.sv
module fsh_unit
  import fsh_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  opnd_a,
  input  logic [AW-1:0] shamt,
  input  logic [2:0]    mode,
  output logic [W-1:0]  res
);
  logic [W-1:0]  y_word;
  logic [W-1:0]  x_word;
  logic [AW-1:0] offset;
  logic [W-1:0]  window;

  fsh_setup #(.W(W), .AW(AW)) u_setup (
    .a      (opnd_a),
    .amt    (shamt),
    .code   (mode),
    .y_word (y_word),
    .x_word (x_word),
    .offset (offset)
  );

  fsh_extract #(.W(W), .AW(AW)) u_extract (
    .cat    ({y_word, x_word}),
    .offset (offset),
    .window (window)
  );

  assign res = window;
endmodule

// File: rtl/fsh_unit_chk.sv
module fsh_unit_chk #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input logic [W-1:0]  a,
  input logic [AW-1:0] amt,
  input logic [2:0]    mode,
  input logic [W-1:0]  res,
  input logic [W-1:0]  y_word
);
  always_comb begin
    if (!$isunknown({a, amt, mode, res, y_word})) begin
      if (mode == 3'b001) AST_SHR_UPPER_ZERO: assert final (y_word == '0); // R2
      if (mode == 3'b000 && amt != '0) AST_SHL_LSB_ZERO: assert final (res[0] == 1'b0); // R1
      if (mode == 3'b010) AST_SAR_SIGN_KEPT: assert final (res[W-1] == a[W-1]); // R3
      if (mode == 3'b011) AST_ROR_POP_KEPT: assert final ($countones(res) == $countones(a)); // R4
      if (mode == 3'b100) AST_ROL_POP_KEPT: assert final ($countones(res) == $countones(a)); // R5
      if (amt == '0) AST_ZERO_AMT_PASS: assert final (res == a); // R6
      if (mode > 3'b100) AST_UNDEF_PASS: assert final (res == a); // R7
    end
  end
endmodule

bind fsh_unit fsh_unit_chk #(.W(W), .AW(AW)) u_chk (
  .a      (opnd_a),
  .amt    (shamt),
  .mode   (mode),
  .res    (res),
  .y_word (y_word)
);

// File: tb/sim_fsh_unit.sv
module sim_fsh_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [4:0]  shamt = '0;
  logic [2:0]  mode = '0;
  logic [31:0] res;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fsh_unit u0 (.opnd_a(opnd_a), .shamt(shamt), .mode(mode), .res(res));

  // fields: mode[71:69] amt[68:64] operand[63:32] expected[31:0]
  localparam int NV = 13;
  localparam logic [71:0] VEC [NV] = '{
    {3'b000, 5'd4,  32'h0000_0001, 32'h0000_0010},
    {3'b000, 5'd31, 32'hFFFF_FFFF, 32'h8000_0000},
    {3'b001, 5'd31, 32'h8000_0000, 32'h0000_0001},
    {3'b001, 5'd8,  32'hF000_000F, 32'h00F0_0000},
    {3'b010, 5'd31, 32'h8000_0000, 32'hFFFF_FFFF},
    {3'b010, 5'd4,  32'h7000_0000, 32'h0700_0000},
    {3'b011, 5'd1,  32'h0000_0001, 32'h8000_0000},
    {3'b011, 5'd4,  32'h1234_5678, 32'h8123_4567},
    {3'b100, 5'd1,  32'h8000_0000, 32'h0000_0001},
    {3'b100, 5'd8,  32'h1234_5678, 32'h3456_7812},
    {3'b101, 5'd7,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {3'b110, 5'd31, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
    {3'b111, 5'd1,  32'h1357_9BDF, 32'h1357_9BDF}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s mode=%b amt=%0d a=%h got=%h exp=%h", tag, mode, shamt, opnd_a, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_op(input logic [2:0] m, input logic [31:0] a, input int s);
    case (m)
      3'b000: return a << s;
      3'b001: return a >> s;
      3'b010: return 32'($signed(a) >>> s);
      3'b011: return (s == 0) ? a : ((a >> s) | (a << (32 - s)));
      3'b100: return (s == 0) ? a : ((a << s) | (a >> (32 - s)));
      default: return a;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [2:0] m, input logic [4:0] s, input logic [31:0] a);
    @(posedge clk);
    mode = m; shamt = s; opnd_a = a;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset state", res, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][71:69], VEC[i][68:64], VEC[i][63:32]);
      chk(tag_of(VEC[i][71:69]), res, VEC[i][31:0]);
    end

    for (int m = 0; m < 5; m++) begin
      for (int s = 0; s < 32; s++) begin
        logic [31:0] a;
        a = $urandom;
        apply(3'(m), 5'(s), a);
        chk(tag_of(3'(m)), res, ref_op(3'(m), a, s));
      end
    end

    // zero amount on every code, including left codes (offset wrap case)
    for (int m = 0; m < 8; m++) begin
      apply(3'(m), 5'd0, 32'hA5C3_0F81);
      chk("R6", res, 32'hA5C3_0F81);
    end

    // undefined codes at every amount leave the word untouched
    for (int s = 0; s < 32; s++) begin
      apply(3'b110, 5'(s), 32'h8000_0001);
      chk("R7", res, 32'h8000_0001);
    end

    apply(3'b010, 5'd31, 32'h7FFF_FFFF);
    chk("R3 positive fill", res, 32'h0);
    apply(3'b100, 5'd31, 32'h0000_0001);
    chk("R5 wrap", res, 32'h8000_0000);
    apply(3'b011, 5'd31, 32'h8000_0000);
    chk("R4 wrap", res, 32'h0000_0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule